// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

The block turns a clock into the coil excitation for a four-phase stepper motor. It drives an 8-bit phase port and walks through a fixed ring of four patterns held in the upper nibble, one pattern per step. A countdown timer spaces the steps. The timer takes its reload value from an input at the start of each interval and counts it down to zero. A direction select walks the ring forwards (clockwise) or backwards (anticlockwise). A one-cycle strobe marks every step. While enabled, the block steps without end.

After reset, the port shows the first pattern of whichever direction is selected. From there a direction change never jumps back to the start of the ring. At the next step the sequencer moves to the neighbouring entry in the new order. When enable is low, both the pattern and the countdown freeze.

Top module: `stepper_seq`

## Requirements
- R1: While in reset, and until the first step after reset, `phase_o` shows the first entry of the selected direction: 0x80 when `dir_ccw_i`=0 and 0xC0 when `dir_ccw_i`=1. `step_o` is low in this period.
- R2: With `dir_ccw_i`=0 (clockwise), successive steps show 0x80, 0xA0, 0xE0, 0xC0, and then wrap back to 0x80.
- R3: With `dir_ccw_i`=1 (anticlockwise), successive steps show 0xC0, 0xE0, 0xA0, 0x80, and then wrap back to 0xC0.
- R4: `phase_o[3:0]` is 0 in every cycle.
- R5: Let N be `delay_i` sampled on the first enabled clock of an interval. The next step takes effect on the N-th enabled clock of that interval. A new interval starts on the enabled clock after a step. A change to `delay_i` in the middle of an interval has no effect until the next interval.
- R6: A sampled `delay_i` of 0 behaves as 1, so a step takes effect on every enabled clock.
- R7: `dir_ccw_i` is sampled on the stepping clock. After a direction change, the step goes to the ring entry next to the current one in the new order, not to the first entry.
- R8: While `en_i` is low, no step occurs, the countdown holds its value, and once the block has left its reset state `phase_o` holds. When `en_i` goes high again, the interval resumes where it stopped.
- R9: `step_o` is high for exactly one cycle per step. It is high in the same cycle that the new pattern first shows on `phase_o`, and it is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low freezes pattern and countdown |
| dir_ccw_i | input | 1 | 0 = clockwise order, 1 = anticlockwise order |
| delay_i | input | DLY_W | Interval reload in clocks (0 treated as 1) |
| phase_o | output | 8 | Coil excitation pattern, upper nibble active |
| step_o | output | 1 | One-cycle strobe in the cycle a new pattern appears |

## Verification
The bench reverses direction in the middle of the ring and at the wrap point. A design that restarted the table on reversal would show 0x80 or 0xC0 where a neighbouring entry is due. It pauses enable in the middle of an interval and changes the reload value there. A counter that kept running, or that reloaded early, would move the step by a cycle or more. A zero reload is tested against the one-step-per-clock rule, because an ordinary down-counter would wrap and stall for a full counter period. Toggling the direction before the first step tests that the home pattern follows the selected direction and that no strobe fires while it does.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int unsigned PHASE_W   = 8;
  localparam int unsigned NUM_STEPS = 4;
  localparam int unsigned IDX_W     = $clog2(NUM_STEPS);

  typedef logic [IDX_W-1:0]   step_idx_t;
  typedef logic [PHASE_W-1:0] phase_t;

  // ring position -> excitation, clockwise walks the index upwards
  function automatic phase_t phase_pattern(step_idx_t idx);
    phase_t p;
    case (idx)
      2'd0:    p = 8'h80;
      2'd1:    p = 8'hA0;
      2'd2:    p = 8'hE0;
      default: p = 8'hC0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/stepper_timer.sv
module stepper_timer #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DLY_W-1:0] reload_i,
  output logic             expire_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] load_val;
  logic [DLY_W-1:0] remain;
  logic             need_q;

  assign load_val = (reload_i == '0) ? ONE : reload_i;
  assign remain   = need_q ? load_val : cnt_q;
  assign expire_o = en_i && (remain == ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      need_q <= 1'b1;
    end else if (en_i) begin
      if (remain == ONE) begin
        need_q <= 1'b1;
      end else begin
        cnt_q  <= remain - ONE;
        need_q <= 1'b0;
      end
    end
  end

  // R8
  hold_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && $stable(need_q)));

  // R5
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !need_q && cnt_q > ONE) |=> (!need_q && cnt_q == $past(cnt_q) - ONE));

  // R6
  zero_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && need_q && reload_i == '0) |-> expire_o);
endmodule

// File: rtl/stepper_index.sv
module stepper_index
  import stepper_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      step_i,
  input  logic      dir_ccw_i,
  output step_idx_t idx_o,
  output logic      home_o
);
  localparam step_idx_t LAST = IDX_W'(NUM_STEPS - 1);
  localparam step_idx_t INC  = IDX_W'(1);

  step_idx_t idx_q;
  step_idx_t idx_nxt;
  logic      home_q;

  // before the first step the position follows the selected direction
  assign idx_o   = home_q ? (dir_ccw_i ? LAST : '0) : idx_q;
  assign idx_nxt = dir_ccw_i ? (idx_o - INC) : (idx_o + INC);
  assign home_o  = home_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      home_q <= 1'b1;
    end else if (step_i) begin
      idx_q  <= idx_nxt;
      home_q <= 1'b0;
    end
  end

  // R7
  adjacent_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (idx_q == ($past(dir_ccw_i) ? ($past(idx_o) - INC) : ($past(idx_o) + INC))));

  // R1
  home_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (home_q && !step_i) |=> home_q);

  // R1
  home_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> !home_q);
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stepper_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dir_ccw_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic [7:0]       phase_o,
  output logic             step_o
);
  logic      expire;
  logic      home;
  logic      step_q;
  step_idx_t idx;

  stepper_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .reload_i (delay_i),
    .expire_o (expire)
  );

  stepper_index u_index (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (expire),
    .dir_ccw_i (dir_ccw_i),
    .idx_o     (idx),
    .home_o    (home)
  );

  // strobe registered alongside the index so it aligns with the new pattern
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= 1'b0;
    else         step_q <= expire;
  end

  assign phase_o = phase_pattern(idx);
  assign step_o  = step_q;

  // R4
  low_nibble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[3:0] == 4'h0);

  // R9
  strobe_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> (phase_o != $past(phase_o)));

  // R9
  strobe_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> $past(en_i));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !home) |=> ($stable(phase_o) && !step_o));
endmodule

// File: tb/stepper_seq_tb.sv
module stepper_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W      = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic             dir_ccw = 1'b0;
  logic [DLY_W-1:0] dly = '0;
  logic [7:0]       phase;
  logic             step;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  logic [7:0] cw_seq [4] = '{8'h80, 8'hA0, 8'hE0, 8'hC0};

  // reference model state
  int m_pos;
  bit m_home;
  int m_rem;
  bit m_need;
  bit m_step;

  stepper_seq #(.DLY_W(DLY_W)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .dir_ccw_i (dir_ccw),
    .delay_i   (dly),
    .phase_o   (phase),
    .step_o    (step)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_pos();
    if (m_home) return dir_ccw ? 3 : 0;
    return m_pos;
  endfunction

  task automatic model_reset();
    m_pos = 0; m_home = 1'b1; m_rem = 0; m_need = 1'b1; m_step = 1'b0;
  endtask

  task automatic compare();
    check(cur_req, "phase", phase, cw_seq[exp_pos()]);
    check("R9", "strobe", {7'b0, step}, {7'b0, m_step});
    check("R4", "low nibble", {4'b0, phase[3:0]}, 8'h00);
  endtask

  task automatic model_advance();
    int n;
    int r;
    int base;
    m_step = 1'b0;
    if (en) begin
      n = (int'(dly) == 0) ? 1 : int'(dly);
      r = m_need ? n : m_rem;
      if (r == 1) begin
        base   = exp_pos();
        m_pos  = dir_ccw ? (base + 3) % 4 : (base + 1) % 4;
        m_home = 1'b0;
        m_need = 1'b1;
        m_step = 1'b1;
      end else begin
        m_rem  = r - 1;
        m_need = 1'b0;
      end
    end
  endtask

  task automatic cyc(bit e, bit d, int dl);
    @(negedge clk);
    en = e; dir_ccw = d; dly = DLY_W'(dl);
    #1;
    compare();
    model_advance();
  endtask

  task automatic do_reset(bit d);
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; dir_ccw = d; dly = '0;
    model_reset();
    #1;
    // R1 during reset
    check("R1", "phase in reset", phase, d ? 8'hC0 : 8'h80);
    check("R1", "strobe in reset", {7'b0, step}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "phase after reset", phase, d ? 8'hC0 : 8'h80);
  endtask

  initial begin
    model_reset();
    // R2 clockwise, step every clock
    do_reset(1'b0);
    cur_req = "R2";
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, 0);

    // R3 anticlockwise ring
    do_reset(1'b1);
    cur_req = "R3";
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, 1);

    // R1 home follows direction, no strobe while disabled
    do_reset(1'b0);
    cur_req = "R1";
    for (int i = 0; i < 8; i++) cyc(1'b0, i[0], 3);

    // R5 interval length, reload change mid interval
    cur_req = "R5";
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 3);
    for (int i = 0; i < 30; i++) cyc(1'b1, 1'b0, (i % 4 == 1) ? 7 : 5);

    // R6 zero reload after a longer interval
    cur_req = "R6";
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 0);

    // R8 enable gaps inside intervals
    cur_req = "R8";
    for (int i = 0; i < 45; i++) cyc((i % 3) != 0, 1'b1, 4);
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 2);

    // R7 reversal at arbitrary ring positions
    cur_req = "R7";
    for (int i = 0; i < 40; i++) cyc(1'b1, ((i / 5) % 2) == 1, 2);
    for (int i = 0; i < 16; i++) cyc(1'b1, ((i / 3) % 2) == 1, 0);

    // R5 long interval
    cur_req = "R5";
    for (int i = 0; i < 700; i++) cyc(1'b1, 1'b1, 300);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule